// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

A processor-addressed peripheral with two 8-bit bidirectional ports, A and B. The processor reaches it through an 8-bit data bus with a 4-bit register address, a read/not-write line, an access strobe and two chip selects, one active high and one active low. Each port has a direction register, an output-value register and an input capture register. Every pin comes out as a separate output value and output enable, so the tristate buffer sits outside the block.

The input side of each port can run in one of two modes. In the first, reads see the live pins. In the second, a control input (one per port) captures the pins into the capture register on its active edge, and reads return the captured byte. The active edge of each control input is programmable. The two ports differ when pins set as outputs are read back. Port A always returns the pin view. Port B returns its own output register for those bits.

All registers sit in the system clock domain. A write takes effect at the clock edge on which the strobe is sampled high. Reads are combinational while the strobe is held.

Top module: `pio_dual_port`

## Requirements
- R1: The block accepts a write and drives the data bus only while `cs_en`=1 and `cs_n`=0. Otherwise writes leave every register unchanged, and `bus_oe`=0 with `bus_out`=0.
- R2: Register addresses: 0x0 is port B value, 0x1 is port A value, 0x2 is port B direction, 0x3 is port A direction, 0xB is latch control and 0xC is edge control. The direction, latch control and edge control registers read back the full byte last written.
- R3: While `rst_n`=0, both direction registers, both output registers, latch control and edge control are zero, so every pin enable is 0.
- R4: `pX_oe[i]` equals direction bit i (1 = output). `pX_out` always shows the last value written to that port's value address, including bits that are currently inputs.
- R5: A read of port A returns the live `pa_in` for all bits when latch control bit 0 is 0, whatever the direction. When that bit is 1, it returns the capture register.
- R6: A read of port B returns the output register for bits whose direction is 1. For the other bits it returns live `pb_in` when latch control bit 1 is 0, and the capture register when that bit is 1.
- R7: When a port's latch bit is 1, an active edge of its control input captures that port's pins into its capture register. The control input passes through a two-stage synchroniser, so the capture takes place at the third rising clock edge after the control input changes. Edge control bit 0 (port A) and bit 4 (port B) select the active edge: 0 = falling, 1 = rising. When the latch bit is 0, no capture takes place.
- R8: The capture register holds its value through edges of the inactive polarity and through changes on the pins.
- R9: Addresses not listed in R2 read as zero, with `bus_oe`=1, and writes to them change nothing.
- R10: `bus_oe` is 1 only while `bus_stb`=1 and `rd_nwr`=1 with the block selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_en | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| bus_addr | input | 4 | Register address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_stb | input | 1 | Access strobe |
| bus_in | input | 8 | Write data |
| bus_out | output | 8 | Read data, zero when not driving |
| bus_oe | output | 1 | Data bus drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A per-pin drive enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B per-pin drive enables |
| ctl_a | input | 1 | Port A capture control input |
| ctl_b | input | 1 | Port B capture control input |

## Verification
The hardest case to reach is a capture register that must keep an old value. This happens when an inactive-polarity edge arrives, when an active edge arrives while latching is off, or when the polarity is flipped while the control input rests at one level. The stimulus first captures a known byte. It then moves the pins to new values, applies these non-capturing edges and waits out the synchroniser latency. Only then does it turn latching on, so that a read shows whether the stale byte survived. Port B is also read with mixed directions, which checks that the output-register bits and the captured bits merge correctly.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam logic [3:0] ADR_VAL_B  = 4'h0;
   localparam logic [3:0] ADR_VAL_A  = 4'h1;
   localparam logic [3:0] ADR_DIR_B  = 4'h2;
   localparam logic [3:0] ADR_DIR_A  = 4'h3;
   localparam logic [3:0] ADR_LATCH  = 4'hB;
   localparam logic [3:0] ADR_EDGE   = 4'hC;

   localparam int LATCH_BIT_A = 0;
   localparam int LATCH_BIT_B = 1;
   localparam int EDGE_BIT_A  = 0;
   localparam int EDGE_BIT_B  = 4;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_VAL_B, SEL_VAL_A, SEL_DIR_B, SEL_DIR_A, SEL_LATCH, SEL_EDGE
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [3:0] a);
      case (a)
         ADR_VAL_B: return SEL_VAL_B;
         ADR_VAL_A: return SEL_VAL_A;
         ADR_DIR_B: return SEL_DIR_B;
         ADR_DIR_A: return SEL_DIR_A;
         ADR_LATCH: return SEL_LATCH;
         ADR_EDGE:  return SEL_EDGE;
         default:   return SEL_NONE;
      endcase
   endfunction
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic rise_sel,
   output logic hit
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pio_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], raw};
   end

   logic now_lvl, old_lvl;
   assign now_lvl = chain_q[STAGES-1];
   assign old_lvl = chain_q[STAGES];
   assign hit = rise_sel ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);

   p_one_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/pio_port.sv
module pio_port #(
   parameter int W            = 8,
   parameter bit OUTS_FROM_REG = 1'b0,
   parameter int SYNC_STAGES  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_we,
   input  logic         val_we,
   input  logic [W-1:0] wdata,
   input  logic         latch_en,
   input  logic         rise_sel,
   input  logic         ctl_raw,
   input  logic [W-1:0] pins_in,
   output logic [W-1:0] pins_out,
   output logic [W-1:0] pins_oe,
   output logic [W-1:0] dir_val,
   output logic [W-1:0] rd_val
);
   generate
      if (W < 1) begin : g_bad_w
         $error("pio_port: W must be positive");
      end
   endgenerate

   logic [W-1:0] dir_q, val_q, cap_q, in_view;
   logic         take;

   pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(ctl_raw), .rise_sel(rise_sel), .hit(take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         val_q <= '0;
         cap_q <= '0;
      end else begin
         if (dir_we) dir_q <= wdata;
         if (val_we) val_q <= wdata;
         if (take && latch_en) cap_q <= pins_in;
      end
   end

   assign pins_out = val_q;
   assign pins_oe  = dir_q;
   assign dir_val  = dir_q;
   assign in_view  = latch_en ? cap_q : pins_in;

   generate
      if (OUTS_FROM_REG) begin : g_mixed_read
         always_comb begin
            for (int i = 0; i < W; i++)
               rd_val[i] = dir_q[i] ? val_q[i] : in_view[i];
         end
      end else begin : g_pin_read
         assign rd_val = in_view;
      end
   endgenerate

   p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(cap_q));
   p_cap_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |=> $stable(cap_q));
   p_cap_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && latch_en) |=> cap_q == $past(pins_in));
   p_dir_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> pins_oe == $past(wdata));
   p_val_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      val_we |=> pins_out == $past(wdata));
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
   import pio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_en,
   input  logic              cs_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              rd_nwr,
   input  logic              bus_stb,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic              ctl_a,
   input  logic              ctl_b
);
   localparam int CFG_MIN_W = EDGE_BIT_B + 1;

   generate
      if (ADDR_W != 4) begin : g_bad_addr
         $error("pio_dual_port: ADDR_W must be 4");
      end
      if (DATA_W < CFG_MIN_W) begin : g_bad_data
         $error("pio_dual_port: DATA_W too narrow for control fields");
      end
   endgenerate

   logic              picked, acc, wr, rd;
   reg_sel_e          sel;
   logic [DATA_W-1:0] latch_q, edge_q, rd_mux;
   logic [DATA_W-1:0] rd_a, rd_b, dir_a, dir_b;

   assign picked = cs_en & ~cs_n;
   assign acc    = picked & bus_stb;
   assign wr     = acc & ~rd_nwr;
   assign rd     = acc & rd_nwr;
   assign sel    = decode_addr(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         edge_q  <= '0;
      end else if (wr) begin
         if (sel == SEL_LATCH) latch_q <= bus_in;
         if (sel == SEL_EDGE)  edge_q  <= bus_in;
      end
   end

   pio_port #(.W(DATA_W), .OUTS_FROM_REG(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
      .clk(clk), .rst_n(rst_n),
      .dir_we(wr && sel == SEL_DIR_A), .val_we(wr && sel == SEL_VAL_A),
      .wdata(bus_in), .latch_en(latch_q[LATCH_BIT_A]), .rise_sel(edge_q[EDGE_BIT_A]),
      .ctl_raw(ctl_a), .pins_in(pa_in), .pins_out(pa_out), .pins_oe(pa_oe),
      .dir_val(dir_a), .rd_val(rd_a)
   );

   pio_port #(.W(DATA_W), .OUTS_FROM_REG(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
      .clk(clk), .rst_n(rst_n),
      .dir_we(wr && sel == SEL_DIR_B), .val_we(wr && sel == SEL_VAL_B),
      .wdata(bus_in), .latch_en(latch_q[LATCH_BIT_B]), .rise_sel(edge_q[EDGE_BIT_B]),
      .ctl_raw(ctl_b), .pins_in(pb_in), .pins_out(pb_out), .pins_oe(pb_oe),
      .dir_val(dir_b), .rd_val(rd_b)
   );

   always_comb begin
      case (sel)
         SEL_VAL_A: rd_mux = rd_a;
         SEL_VAL_B: rd_mux = rd_b;
         SEL_DIR_A: rd_mux = dir_a;
         SEL_DIR_B: rd_mux = dir_b;
         SEL_LATCH: rd_mux = latch_q;
         SEL_EDGE:  rd_mux = edge_q;
         default:   rd_mux = '0;
      endcase
   end

   assign bus_oe  = rd;
   assign bus_out = rd ? rd_mux : '0;

   p_no_drive_unsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !picked |-> (!bus_oe && bus_out == '0));
   p_no_write_unsel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !picked |=> ($stable(latch_q) && $stable(edge_q) && $stable(pa_oe) && $stable(pb_oe)));
   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && sel == SEL_NONE) |-> bus_out == '0);
   p_b_outbits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && sel == SEL_VAL_B) |-> ((bus_out & pb_oe) == (pb_out & pb_oe)));
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_stb |-> !bus_oe);

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r3: assert (pa_oe == '0 && pb_oe == '0 && pa_out == '0 &&
                                   pb_out == '0 && latch_q == '0 && edge_q == '0);
      end
   end
endmodule

// File: tb/pio_dual_port_tb_top.sv
module pio_dual_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_en = 1'b1, cs_n = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic       rd_nwr = 1'b1, bus_stb = 1'b0;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out, pa_out, pa_oe, pb_out, pb_oe;
   logic       bus_oe;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
   logic       ctl_a = 1'b1, ctl_b = 1'b0;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pio_dual_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .cs_n(cs_n), .bus_addr(bus_addr),
      .rd_nwr(rd_nwr), .bus_stb(bus_stb), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .ctl_a(ctl_a), .ctl_b(ctl_b)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_in = d; rd_nwr = 1'b0; bus_stb = 1'b1;
      @(negedge clk);
      bus_stb = 1'b0; rd_nwr = 1'b1;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      bus_addr = a; rd_nwr = 1'b1; bus_stb = 1'b1;
      #1;
      d = bus_out; oe = bus_oe;
      bus_stb = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d; logic oe;
      chk("R3 pa_oe", pa_oe, 8'h00);
      chk("R3 pb_oe", pb_oe, 8'h00);
      chk("R3 pa_out", pa_out, 8'h00);
      chk("R10 idle oe", {7'd0, bus_oe}, 8'h00);
      rd_reg(4'h3, d, oe); chk("R3 dirA", d, 8'h00);
      chk("R10 read oe", {7'd0, oe}, 8'h01);
      rd_reg(4'h2, d, oe); chk("R3 dirB", d, 8'h00);
      rd_reg(4'hB, d, oe); chk("R3 latch", d, 8'h00);
      rd_reg(4'hC, d, oe); chk("R3 edge", d, 8'h00);
   endtask

   task automatic t_select;
      logic [7:0] d; logic oe;
      cs_en = 1'b0; wr_reg(4'h3, 8'hFF); cs_en = 1'b1;
      chk("R1 no write cs_en", pa_oe, 8'h00);
      cs_n = 1'b1; wr_reg(4'h2, 8'hFF);
      chk("R1 no write cs_n", pb_oe, 8'h00);
      rd_reg(4'h3, d, oe); cs_n = 1'b0;
      chk("R1 no drive oe", {7'd0, oe}, 8'h00);
      chk("R1 no drive data", d, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] d; logic oe;
      wr_reg(4'h3, 8'hF0); wr_reg(4'h1, 8'hA5);
      chk("R4 pa_oe", pa_oe, 8'hF0);
      chk("R4 pa_out", pa_out, 8'hA5);
      wr_reg(4'h0, 8'h3C);
      chk("R4 pb_out while input", pb_out, 8'h3C);
      chk("R4 pb_oe zero", pb_oe, 8'h00);
      rd_reg(4'h3, d, oe); chk("R2 dirA read", d, 8'hF0);
      wr_reg(4'hB, 8'hE0); rd_reg(4'hB, d, oe); chk("R2 latch read", d, 8'hE0);
      wr_reg(4'hC, 8'h6A); rd_reg(4'hC, d, oe); chk("R2 edge read", d, 8'h6A);
      wr_reg(4'hB, 8'h00); wr_reg(4'hC, 8'h00);
   endtask

   task automatic t_live_read;
      logic [7:0] d; logic oe;
      pa_in = 8'h3C; rd_reg(4'h1, d, oe); chk("R5 A live ignores dir", d, 8'h3C);
      pa_in = 8'hC3; rd_reg(4'h1, d, oe); chk("R5 A live follows", d, 8'hC3);
      wr_reg(4'h2, 8'h0F); wr_reg(4'h0, 8'h55); pb_in = 8'hAA;
      rd_reg(4'h0, d, oe); chk("R6 B mixed live", d, (8'h55 & 8'h0F) | (8'hAA & 8'hF0));
   endtask

   task automatic t_cap_a;
      logic [7:0] d; logic oe;
      wr_reg(4'hC, 8'h00); wr_reg(4'hB, 8'h01);
      pa_in = 8'h12; wait_clk(2);
      ctl_a = 1'b0; wait_clk(5);
      pa_in = 8'h34; rd_reg(4'h1, d, oe); chk("R7 A falling capture", d, 8'h12);
      ctl_a = 1'b1; wait_clk(5);
      rd_reg(4'h1, d, oe); chk("R8 A rising ignored", d, 8'h12);
      wr_reg(4'hC, 8'h01);
      ctl_a = 1'b0; pa_in = 8'h99; wait_clk(5);
      rd_reg(4'h1, d, oe); chk("R8 A polarity flip hold", d, 8'h12);
      pa_in = 8'h56; ctl_a = 1'b1; wait_clk(5);
      pa_in = 8'h00; rd_reg(4'h1, d, oe); chk("R7 A rising capture", d, 8'h56);
      wr_reg(4'hB, 8'h00);
      pa_in = 8'h77; ctl_a = 1'b0; wait_clk(3); ctl_a = 1'b1; wait_clk(5);
      rd_reg(4'h1, d, oe); chk("R5 A latch off live", d, 8'h77);
      pa_in = 8'h11; wr_reg(4'hB, 8'h01);
      rd_reg(4'h1, d, oe); chk("R7 A no capture when off", d, 8'h56);
      wr_reg(4'hB, 8'h00);
   endtask

   task automatic t_cap_b;
      logic [7:0] d; logic oe;
      wr_reg(4'hC, 8'h10); wr_reg(4'hB, 8'h02);
      pb_in = 8'hC3; wait_clk(2);
      ctl_b = 1'b1; wait_clk(5);
      pb_in = 8'h3C; rd_reg(4'h0, d, oe);
      chk("R6 B captured mix", d, (8'h55 & 8'h0F) | (8'hC3 & 8'hF0));
      chk("R8 B pins moved, hold", d, 8'hC5);
      ctl_b = 1'b0; wait_clk(5);
      rd_reg(4'h0, d, oe); chk("R8 B falling ignored", d, 8'hC5);
      wr_reg(4'hB, 8'h00);
   endtask

   task automatic t_unmapped;
      logic [7:0] d; logic oe;
      wr_reg(4'h4, 8'hFF); wr_reg(4'hF, 8'hFF);
      rd_reg(4'h4, d, oe); chk("R9 unmapped read zero", d, 8'h00);
      chk("R9 unmapped oe", {7'd0, oe}, 8'h01);
      rd_reg(4'hF, d, oe); chk("R9 unmapped F zero", d, 8'h00);
      chk("R9 dirA untouched", pa_oe, 8'hF0);
      chk("R9 valB untouched", pb_out, 8'h55);
      rd_reg(4'hB, d, oe); chk("R9 latch untouched", d, 8'h00);
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset;
      t_select;
      t_regs;
      t_live_read;
      t_cap_a;
      t_cap_b;
      t_unmapped;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule